// File: doc/BRIEF.md
# Inter-core interrupt doorbell register

This block is a shared control register through which any one of three processor cores can ring a doorbell on the others. A core writes a word to the register's special-register number (947). The write also carries the identity of the core that performs it. Three bits of the written word choose target cores. The bit that would select the writer itself is masked off. Each target bit that is still set produces a single-cycle interrupt request on the line of the matching core.

The register keeps the whole written word, including the writer's own bit, and returns it on a read of the same number. A read of any other number returns zero. Acknowledging the interrupt inside each core is left to the cores.

Top module: `xcore_doorbell`

## Requirements
- R1: A write with `acc_num` equal to 947 stores all 32 bits of `wr_data`. From the next cycle, `rd_data` returns that word whenever `acc_num` is 947.
- R2: A write to any other number leaves the stored word unchanged and raises no request. A read of any other number returns zero.
- R3: Target bits map to cores MSB-first by core ID. Bit 20 selects core 0 (`ipi_req[0]`), bit 19 selects core 1 (`ipi_req[1]`) and bit 18 selects core 2 (`ipi_req[2]`). Bit 0 is the LSB. No other bit of `wr_data` raises a request.
- R4: When `wr_core` is 0, 1 or 2, the bit at position (20 - `wr_core`) is cleared before decoding, so the writing core never receives a request from its own write.
- R5: The stored word includes the writer's own target bit, unmasked.
- R6: A request is a pulse one cycle long. It is high only in the cycle that follows the accepted write, and it is zero in every cycle that does not follow such a write.
- R7: When `wr_core` is 3, no bit is masked. Every set target bit raises its request.
- R8: While `rst_n` is low, the stored word is zero and all requests are zero. No request follows reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_num | input | 10 | Special-register number for the current read or write |
| wr_en | input | 1 | Write strobe for the current cycle |
| wr_data | input | 32 | Word to be written |
| wr_core | input | 2 | Identity of the writing core |
| rd_data | output | 32 | Stored word when `acc_num` is 947, zero otherwise |
| ipi_req | output | 3 | Per-core interrupt request pulses, bit i for core i |

## Verification
The assertions take for granted that `wr_en` is low while reset is held. Under that condition, the first request after reset can trace back only to a real write. They also take for granted that `wr_core` is stable and valid in the cycle of the write, because the self-mask and full-pass checks compare against its previous value. The stimulus changes inputs only on the falling edge and keeps `wr_en` low around both reset phases. It steps `wr_core` through every code, including 3, so that each mask branch is covered.

// File: rtl/dbell_pkg.sv
package dbell_pkg;
  localparam int DB_DATA_W    = 32;
  localparam int DB_CID_W     = 2;
  localparam int DB_NUM_CORES = 3;
  localparam int DB_TOP_BIT   = 20;
  localparam int DB_SPR_W     = 10;
  localparam int DB_REG_NUM   = 947;
endpackage

// File: rtl/dbell_decode.sv
module dbell_decode #(
  parameter int CID_W     = 2,
  parameter int NUM_CORES = 3
) (
  input  logic [NUM_CORES-1:0] field,
  input  logic [CID_W-1:0]     core_id,
  output logic [NUM_CORES-1:0] self_bit,
  output logic [NUM_CORES-1:0] targets
);
  // field[NUM_CORES-1] is the highest target bit and belongs to core 0
  function automatic logic is_self(input logic [CID_W-1:0] id, input int core);
    return id == CID_W'(core);
  endfunction

  for (genvar g = 0; g < NUM_CORES; g++) begin : g_core
    assign self_bit[g] = is_self(core_id, g);
    assign targets[g]  = field[NUM_CORES-1-g] & ~self_bit[g];
  end
endmodule

// File: rtl/dbell_store.sv
module dbell_store #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= din;
  end
endmodule

// File: rtl/dbell_pulse.sv
module dbell_pulse #(
  parameter int NUM_CORES = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fire,
  input  logic [NUM_CORES-1:0] targets,
  output logic [NUM_CORES-1:0] req
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    req <= '0;
    else if (fire) req <= targets;
    else           req <= '0;
  end
endmodule

// File: rtl/xcore_doorbell.sv
module xcore_doorbell
  import dbell_pkg::*;
#(
  parameter int DATA_W    = DB_DATA_W,
  parameter int CID_W     = DB_CID_W,
  parameter int NUM_CORES = DB_NUM_CORES,
  parameter int TOP_BIT   = DB_TOP_BIT,
  parameter int SPR_W     = DB_SPR_W,
  parameter int REG_NUM   = DB_REG_NUM
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [SPR_W-1:0]     acc_num,
  input  logic                 wr_en,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic [CID_W-1:0]     wr_core,
  output logic [DATA_W-1:0]    rd_data,
  output logic [NUM_CORES-1:0] ipi_req
);
  localparam int LOW_BIT = TOP_BIT - NUM_CORES + 1;

  logic                 num_hit;
  logic                 wr_hit;
  logic [NUM_CORES-1:0] tgt_field;
  logic [NUM_CORES-1:0] self_bit;
  logic [NUM_CORES-1:0] tgt_dec;
  logic [DATA_W-1:0]    reg_q;

  assign num_hit   = acc_num == SPR_W'(REG_NUM);
  assign wr_hit    = wr_en & num_hit;
  assign tgt_field = wr_data[TOP_BIT:LOW_BIT];

  dbell_decode #(.CID_W(CID_W), .NUM_CORES(NUM_CORES)) u_dec (
    .field(tgt_field), .core_id(wr_core), .self_bit(self_bit), .targets(tgt_dec)
  );

  dbell_store #(.DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n), .load(wr_hit), .din(wr_data), .q(reg_q)
  );

  dbell_pulse #(.NUM_CORES(NUM_CORES)) u_pulse (
    .clk(clk), .rst_n(rst_n), .fire(wr_hit), .targets(tgt_dec), .req(ipi_req)
  );

  assign rd_data = num_hit ? reg_q : '0;
endmodule

// File: rtl/dbell_checker.sv
module dbell_checker #(
  parameter int DATA_W    = 32,
  parameter int CID_W     = 2,
  parameter int NUM_CORES = 3,
  parameter int TOP_BIT   = 20
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wr_hit,
  input logic [CID_W-1:0]     wr_core,
  input logic [DATA_W-1:0]    wr_data,
  input logic [DATA_W-1:0]    reg_q,
  input logic [NUM_CORES-1:0] self_bit,
  input logic [NUM_CORES-1:0] ipi_req
);
  AST_STORE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> reg_q == $past(wr_data)); // R5

  AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(reg_q)); // R2

  AST_REQ_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (ipi_req != '0) |-> $past(wr_hit)); // R6

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |-> (reg_q == '0 && ipi_req == '0)); // R8

  AST_SELF_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(self_bit)); // R4

  for (genvar g = 0; g < NUM_CORES; g++) begin : g_chk
    AST_TARGET_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      ipi_req[g] |-> $past(wr_data[TOP_BIT-g])); // R3

    AST_NO_SELF: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && wr_core == CID_W'(g)) |=> !ipi_req[g]); // R4

    AST_FULL_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && wr_core >= CID_W'(NUM_CORES)) |=> ipi_req[g] == $past(wr_data[TOP_BIT-g])); // R7
  end
endmodule

bind xcore_doorbell dbell_checker #(
  .DATA_W(DATA_W), .CID_W(CID_W), .NUM_CORES(NUM_CORES), .TOP_BIT(TOP_BIT)
) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .wr_core(wr_core), .wr_data(wr_data),
  .reg_q(reg_q), .self_bit(self_bit), .ipi_req(ipi_req)
);

// File: tb/xcore_doorbell_tb_top.sv
`timescale 1ns/1ps
module xcore_doorbell_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  acc_num = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [1:0]  wr_core = '0;
  logic [31:0] rd_data;
  logic [2:0]  ipi_req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct { logic [2:0] ipi; string tag; } exp_t;
  exp_t sb_q[$];

  always #2.5 clk = ~clk;

  xcore_doorbell dut_i (
    .clk(clk), .rst_n(rst_n), .acc_num(acc_num), .wr_en(wr_en),
    .wr_data(wr_data), .wr_core(wr_core), .rd_data(rd_data), .ipi_req(ipi_req)
  );

  function automatic logic [2:0] model_ipi(input logic [31:0] d, input logic [1:0] c);
    logic [2:0] t;
    t = {d[18], d[19], d[20]};
    if (c != 2'd3) t[c] = 1'b0;
    return t;
  endfunction

  task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic w, input logic [9:0] n, input logic [31:0] d,
                     input logic [1:0] c, input string tag);
    exp_t e;
    @(negedge clk);
    wr_en = w; acc_num = n; wr_data = d; wr_core = c;
    e.ipi = (w && n == 10'd947) ? model_ipi(d, c) : 3'b000;
    e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic rd(input logic [9:0] n, input logic [31:0] exp, input string tag);
    cyc(1'b0, n, 32'h0, 2'd0, tag);
    #1 check32(tag, rd_data, exp);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        e = sb_q.pop_front();
        check32(e.tag, {29'h0, ipi_req}, {29'h0, e.ipi});
      end
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    check32("R8 reset req", {29'h0, ipi_req}, 32'h0);
    acc_num = 10'd947;
    #1 check32("R8 reset store", rd_data, 32'h0);
    rst_n = 1'b1;
    cyc(1'b0, 10'd0, 32'h0, 2'd0, "R8 no req after reset");
    cyc(1'b1, 10'd947, 32'h001C_0000, 2'd0, "R4 core0 all");
    rd(10'd947, 32'h001C_0000, "R5 self bit stored");
    cyc(1'b1, 10'd947, 32'h001C_0000, 2'd1, "R4 core1 all");
    cyc(1'b1, 10'd947, 32'h001C_0000, 2'd2, "R4 core2 all");
    cyc(1'b1, 10'd947, 32'h001C_0000, 2'd3, "R7 core3 all");
    cyc(1'b0, 10'd947, 32'h0, 2'd0, "R6 idle after write");
    cyc(1'b1, 10'd947, 32'h0010_0000, 2'd2, "R3 bit20 core0");
    cyc(1'b1, 10'd947, 32'h0008_0000, 2'd0, "R3 bit19 core1");
    cyc(1'b1, 10'd947, 32'h0004_0000, 2'd1, "R3 bit18 core2");
    cyc(1'b1, 10'd947, 32'h0010_0000, 2'd0, "R4 only self bit");
    cyc(1'b1, 10'd947, 32'h0008_0000, 2'd3, "R7 single bit");
    cyc(1'b1, 10'd947, 32'hFFE3_FFFF, 2'd3, "R3 other bits");
    rd(10'd947, 32'hFFE3_FFFF, "R1 full word");
    cyc(1'b1, 10'd948, 32'h001C_0000, 2'd3, "R2 other number");
    rd(10'd947, 32'hFFE3_FFFF, "R2 store kept");
    rd(10'd948, 32'h0, "R2 other read zero");
    cyc(1'b1, 10'd947, 32'h1234_5678, 2'd1, "R1 write");
    rd(10'd947, 32'h1234_5678, "R1 readback");
    cyc(1'b0, 10'd947, 32'h0, 2'd0, "R6 idle");
    cyc(1'b0, 10'd947, 32'h0, 2'd0, "R6 idle");
    @(negedge clk);
    rst_n = 1'b0;
    #1 check32("R8 mid reset store", rd_data, 32'h0);
    check32("R8 mid reset req", {29'h0, ipi_req}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    cyc(1'b0, 10'd947, 32'h0, 2'd0, "R8 quiet after reset");
    rd(10'd947, 32'h0, "R8 store zero");
    repeat (3) @(negedge clk);
    done = 1'b1;
  end

  initial begin : finisher
    fork
      wait (done);
      begin
        #20000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule